// File: doc/BRIEF.md
# Front-to-Back Coverage Compositor

This block accumulates shaded pixel fragments for one screen tile of `PART_W` x `PART_H` pixels into a per-pixel composite word, front to back. Each fragment carries a premultiplication-free color, an alpha, an 8-sample coverage mask and a two-bit code that gives its depth relation to what is already composited. That relation is computed upstream. The block scales each fragment by the share of samples it covers and blends it behind the accumulated result. It also keeps one opacity flag per pixel. The flag decides whether later coverage masks are merged or clipped.

There are two banks of storage. One bank is composited while the other is read out through a scanout port. A tile-end token swaps the roles of the two banks. The token also reports whether any pixel lost data that was still visible, so that the tile has to be sent again.

A stored word holds `{red, green, blue, alpha, mask}`, each field 8 bits, with red in the top byte. The colors in the stored word are premultiplied by alpha.

Top module: `coverage_compositor`

## Requirements
- R1: After reset, every scanout read returns 0, `resub_valid` is low, and both banks are empty.
- R2: The clipped coverage `n` is the number of set bits in the clipped mask. The scaled alpha is `as = round(alpha*n/8)`, with halves rounded up. The premultiplied channel is `round(c*as/255)`.
- R3: Relation code 00 (in front of everything composited so far) overwrites the word. The new word is the premultiplied channels, `as`, and the unclipped fragment mask, and the opacity flag is cleared.
- R4: Relation code 01 (behind) updates each channel as `stored + round((255-stored_alpha)*new/255)`, saturating at 255. Alpha is updated by the same rule using `as`.
- R5: For code 01, the fragment mask replaces the stored mask and the flag is set when all of these hold: the flag is clear, the stored mask is nonzero, the stored mask covers every fragment sample, and the fragment alpha is greater than the stored alpha. Otherwise the new mask is the stored mask OR the clipped mask.
- R6: For code 01, while a pixel's flag is set, the fragment mask is ANDed with the inverse of the stored mask before scaling. The flag then stays set.
- R7: Code 10 (equal depth) always clips the fragment mask by the stored mask. It then blends as R4, merges masks by OR, and leaves the flag unchanged. The fragment that arrived earlier counts as the front one.
- R8: Code 11 leaves the stored word unchanged.
- R9: A code-00 write over a pixel whose stored mask is nonzero marks that pixel for resubmission when its scaled alpha is below 255. One cycle after a tile-end token, `resub_valid` pulses. `resub_need` is 1 in that cycle if any pixel was marked, and all marks are cleared.
- R10: A tile-end token swaps the banks. Scanout then shows the finished tile with one cycle of read latency. The bank taken up for compositing starts empty, and writes to it do not change the displayed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_addr | input | AW (9) | Pixel index within the tile |
| frag_rel | input | 2 | Depth relation code: 00 front, 01 behind, 10 equal, 11 skip |
| frag_color | input | 24 | Fragment color {r,g,b}, not premultiplied |
| frag_alpha | input | 8 | Fragment alpha, 255 = opaque |
| frag_mask | input | 8 | Sample coverage mask |
| sync_valid | input | 1 | Tile-end token; swaps banks |
| rd_addr | input | AW (9) | Scanout pixel index |
| rd_data | output | 40 | Displayed word {r,g,b,alpha,mask}, one cycle after rd_addr |
| resub_valid | output | 1 | Pulse one cycle after a tile-end token |
| resub_need | output | 1 | Another pass of the tile is required |

## Verification
A wrong opacity flag or a wrong stored mask inside a bank does not show at the ports during compositing. It shows only after the next tile-end token, in the alpha and mask bytes of `rd_data` for that pixel, one cycle after the address is presented. The same holds when a resubmission mark is lost or set when it should not be: the error appears only as a wrong `resub_need` in the single cycle after the token. The bench therefore composes short histories on chosen pixels, ends the tile, and sweeps the scanout, comparing every cycle against a behavioural model.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int CW     = 8;
    localparam int NCH    = 3;
    localparam int MW     = 8;
    localparam int CNT_W  = $clog2(MW) + 1;
    localparam int WORD_W = NCH * CW + CW + MW;

    typedef enum logic [1:0] {
        REL_LOAD   = 2'b00,
        REL_BEHIND = 2'b01,
        REL_EQUAL  = 2'b10,
        REL_SKIP   = 2'b11
    } rel_e;

    typedef struct packed {
        logic [NCH*CW-1:0] color;
        logic [CW-1:0]     alpha;
        logic [MW-1:0]     mask;
    } pix_t;

    typedef struct packed {
        pix_t pix;
        logic opq;
    } cell_t;

    // round(x*y / (2^CW-1)), exact round-to-nearest for CW = 8
    function automatic logic [CW-1:0] mul_norm(input logic [CW-1:0] x, input logic [CW-1:0] y);
        logic [2*CW:0] t;
        t = (2*CW+1)'(x) * (2*CW+1)'(y) + (2*CW+1)'(2 ** (CW - 1));
        return CW'((t + (t >> CW)) >> CW);
    endfunction

    function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] x, input logic [CW-1:0] y);
        logic [CW:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[CW] ? '1 : s[CW-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] popcnt(input logic [MW-1:0] m);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < MW; i++) c = c + CNT_W'(m[i]);
        return c;
    endfunction

    // alpha scaled by covered share of samples, halves rounded up
    function automatic logic [CW-1:0] scale_cov(input logic [CW-1:0] a, input logic [CNT_W-1:0] n);
        logic [CW+CNT_W-1:0] p;
        p = (CW+CNT_W)'(a) * (CW+CNT_W)'(n) + (CW+CNT_W)'(MW / 2);
        return CW'(p >> $clog2(MW));
    endfunction

endpackage

// File: rtl/cmp_blend.sv
module cmp_blend
    import cmp_pkg::*;
(
    input  cell_t             st,
    input  logic [1:0]        rel,
    input  logic [NCH*CW-1:0] f_color,
    input  logic [CW-1:0]     f_alpha,
    input  logic [MW-1:0]     f_mask,
    output cell_t             nw,
    output logic              contrib
);

    rel_e              r;
    logic [MW-1:0]     sm;
    logic [MW-1:0]     uncov;
    logic [MW-1:0]     clip;
    logic [CNT_W-1:0]  cov;
    logic [CW-1:0]     sc_a;
    logic [CW-1:0]     mix_a;
    logic              rep;
    logic [NCH*CW-1:0] load_col;
    logic [NCH*CW-1:0] mix_col;

    always_comb begin
        r     = rel_e'(rel);
        sm    = st.pix.mask;
        uncov = f_mask & ~sm;
        case (r)
            REL_LOAD:   clip = f_mask;
            REL_BEHIND: clip = st.opq ? uncov : f_mask;
            default:    clip = uncov;
        endcase
        cov     = popcnt(clip);
        sc_a    = scale_cov(f_alpha, cov);
        rep     = (r == REL_BEHIND) && !st.opq && (sm != '0) &&
                  (uncov == '0) && (f_alpha > st.pix.alpha);
        contrib = (r == REL_LOAD) && (sm != '0) && (sc_a != '1);
    end

    assign mix_a = sat_add(st.pix.alpha, mul_norm(~st.pix.alpha, sc_a));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] pre;
        assign pre                   = mul_norm(f_color[g*CW +: CW], sc_a);
        assign load_col[g*CW +: CW]  = pre;
        assign mix_col[g*CW +: CW]   = sat_add(st.pix.color[g*CW +: CW],
                                               mul_norm(~st.pix.alpha, pre));
    end

    always_comb begin
        nw = st;
        if (r == REL_LOAD) begin
            nw.pix.color = load_col;
            nw.pix.alpha = sc_a;
            nw.pix.mask  = f_mask;
            nw.opq       = 1'b0;
        end else begin
            nw.pix.color = mix_col;
            nw.pix.alpha = mix_a;
            nw.pix.mask  = rep ? f_mask : (sm | clip);
            nw.opq       = st.opq | rep;
        end
    end

endmodule

// File: rtl/cmp_store.sv
module cmp_store
    import cmp_pkg::*;
#(
    parameter int NPIX = 512,
    parameter int AW   = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_bank,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  cell_t         wr_cell,
    input  logic [AW-1:0] lk_addr,
    output cell_t         lk_cell,
    input  logic          clr_en,
    input  logic [AW-1:0] rd_addr,
    output pix_t          rd_pix
);

    cell_t            mem [2][NPIX];
    logic [NPIX-1:0]  vld [2];

    assign lk_cell = vld[cmp_bank][lk_addr] ? mem[cmp_bank][lk_addr] : '0;

    always_ff @(posedge clk) begin
        if (wr_en) mem[cmp_bank][wr_addr] <= wr_cell;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld[0] <= '0;
            vld[1] <= '0;
            rd_pix <= '0;
        end else begin
            if (wr_en) vld[cmp_bank][wr_addr] <= 1'b1;
            if (clr_en) vld[~cmp_bank] <= '0;
            rd_pix <= vld[~cmp_bank][rd_addr] ? mem[~cmp_bank][rd_addr].pix : '0;
        end
    end

endmodule

// File: rtl/cmp_resub.sv
module cmp_resub #(
    parameter int NPIX = 512,
    parameter int AW   = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          sync_valid,
    output logic          resub_valid,
    output logic          resub_need
);

    logic [NPIX-1:0] marks;

    always_ff @(posedge clk) begin
        if (rst) begin
            marks       <= '0;
            resub_valid <= 1'b0;
            resub_need  <= 1'b0;
        end else if (sync_valid) begin
            resub_valid <= 1'b1;
            resub_need  <= |marks;
            marks       <= '0;
        end else begin
            resub_valid <= 1'b0;
            resub_need  <= 1'b0;
            if (set_en) marks[set_addr] <= 1'b1;
        end
    end

endmodule

// File: rtl/coverage_compositor.sv
module coverage_compositor
    import cmp_pkg::*;
#(
    parameter int  PART_W = 32,
    parameter int  PART_H = 16,
    localparam int NPIX   = PART_W * PART_H,
    localparam int AW     = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frag_valid,
    input  logic [AW-1:0]     frag_addr,
    input  logic [1:0]        frag_rel,
    input  logic [NCH*CW-1:0] frag_color,
    input  logic [CW-1:0]     frag_alpha,
    input  logic [MW-1:0]     frag_mask,
    input  logic              sync_valid,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              resub_valid,
    output logic              resub_need
);

    logic  cmp_bank;
    logic  wr_en;
    logic  blend_contrib;
    cell_t st_cell;
    cell_t nw_cell;
    pix_t  rd_pix;

    // a fragment sharing its cycle with the tile-end token is dropped
    assign wr_en = frag_valid && !sync_valid && (rel_e'(frag_rel) != REL_SKIP);

    always_ff @(posedge clk) begin
        if (rst) cmp_bank <= 1'b0;
        else if (sync_valid) cmp_bank <= ~cmp_bank;
    end

    cmp_store #(.NPIX(NPIX), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cmp_bank (cmp_bank),
        .wr_en    (wr_en),
        .wr_addr  (frag_addr),
        .wr_cell  (nw_cell),
        .lk_addr  (frag_addr),
        .lk_cell  (st_cell),
        .clr_en   (sync_valid),
        .rd_addr  (rd_addr),
        .rd_pix   (rd_pix)
    );

    cmp_blend u_blend (
        .st      (st_cell),
        .rel     (frag_rel),
        .f_color (frag_color),
        .f_alpha (frag_alpha),
        .f_mask  (frag_mask),
        .nw      (nw_cell),
        .contrib (blend_contrib)
    );

    cmp_resub #(.NPIX(NPIX), .AW(AW)) u_resub (
        .clk         (clk),
        .rst         (rst),
        .set_en      (wr_en && blend_contrib),
        .set_addr    (frag_addr),
        .sync_valid  (sync_valid),
        .resub_valid (resub_valid),
        .resub_need  (resub_need)
    );

    assign rd_data = rd_pix;

endmodule

// File: rtl/cmp_chk.sv
module cmp_chk
    import cmp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          sync_valid,
    input logic          resub_valid,
    input logic          resub_need,
    input logic          bank,
    input logic          we,
    input logic [1:0]    rel,
    input logic [CW-1:0] st_alpha,
    input logic [CW-1:0] nw_alpha,
    input logic          st_opq,
    input logic          nw_opq,
    input logic [MW-1:0] st_mask,
    input logic [MW-1:0] nw_mask
);

    // R9
    resub_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resub_valid |-> $past(sync_valid));

    // R9
    need_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !resub_valid |-> !resub_need);

    // R10
    bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
        sync_valid |=> bank != $past(bank));

    // R4
    alpha_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (we && rel == 2'(REL_BEHIND)) |-> nw_alpha >= st_alpha);

    // R6
    opq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (we && st_opq && rel != 2'(REL_LOAD)) |-> nw_opq);

    // R7
    equal_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (we && rel == 2'(REL_EQUAL)) |-> ((nw_mask & st_mask) == st_mask && nw_opq == st_opq));

    // R8
    skip_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (rel == 2'(REL_SKIP)) |-> !we);

endmodule

bind coverage_compositor cmp_chk i_cmp_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_valid  (sync_valid),
    .resub_valid (resub_valid),
    .resub_need  (resub_need),
    .bank        (cmp_bank),
    .we          (wr_en),
    .rel         (frag_rel),
    .st_alpha    (st_cell.pix.alpha),
    .nw_alpha    (nw_cell.pix.alpha),
    .st_opq      (st_cell.opq),
    .nw_opq      (nw_cell.opq),
    .st_mask     (st_cell.pix.mask),
    .nw_mask     (nw_cell.pix.mask)
);

// File: tb/test_coverage_compositor.sv
module test_coverage_compositor;

    localparam int CLK_NS = 10;
    localparam int NP     = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frag_valid = 1'b0;
    logic [8:0]  frag_addr = '0;
    logic [1:0]  frag_rel = '0;
    logic [23:0] frag_color = '0;
    logic [7:0]  frag_alpha = '0;
    logic [7:0]  frag_mask = '0;
    logic        sync_valid = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [39:0] rd_data;
    logic        resub_valid;
    logic        resub_need;

    always #(CLK_NS/2) clk = ~clk;

    coverage_compositor i_coverage_compositor (
        .clk(clk), .rst(rst), .frag_valid(frag_valid), .frag_addr(frag_addr),
        .frag_rel(frag_rel), .frag_color(frag_color), .frag_alpha(frag_alpha),
        .frag_mask(frag_mask), .sync_valid(sync_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .resub_valid(resub_valid), .resub_need(resub_need)
    );

    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    armed  = 0;
    string cur_req = "R1";

    // behavioural model: two banks, flags and marks as plain integers
    int mc [2][NP][3];
    int ma [2][NP];
    int mm [2][NP];
    int mf [2][NP];
    bit rs [NP];
    int mb;
    logic [39:0] exp_rd;
    logic        exp_rv, exp_rn;
    int db, ra, p, sm, sa, sf, clip, n, as_, rep, fm, fa;
    int col [3];

    function automatic int nrm(int x, int y);
        return (2 * x * y + 255) / 510;
    endfunction

    function automatic int sat(int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int q = 0; q < NP; q++) begin
                    mc[b][q][0] = 0; mc[b][q][1] = 0; mc[b][q][2] = 0;
                    ma[b][q] = 0; mm[b][q] = 0; mf[b][q] = 0;
                end
            for (int q = 0; q < NP; q++) rs[q] = 0;
            mb = 0; exp_rd = '0; exp_rv = 0; exp_rn = 0;
        end else begin
            db = 1 - mb;
            ra = int'(rd_addr);
            exp_rd = {8'(mc[db][ra][0]), 8'(mc[db][ra][1]), 8'(mc[db][ra][2]),
                      8'(ma[db][ra]), 8'(mm[db][ra])};
            exp_rv = sync_valid;
            exp_rn = 0;
            if (sync_valid) begin
                for (int q = 0; q < NP; q++) begin
                    if (rs[q]) exp_rn = 1;
                    rs[q] = 0;
                    mc[db][q][0] = 0; mc[db][q][1] = 0; mc[db][q][2] = 0;
                    ma[db][q] = 0; mm[db][q] = 0; mf[db][q] = 0;
                end
                mb = db;
            end else if (frag_valid && frag_rel != 2'b11) begin
                p  = int'(frag_addr);
                fm = int'(frag_mask); fa = int'(frag_alpha);
                col[0] = int'(frag_color[23:16]);
                col[1] = int'(frag_color[15:8]);
                col[2] = int'(frag_color[7:0]);
                sm = mm[mb][p]; sa = ma[mb][p]; sf = mf[mb][p];
                if (frag_rel == 2'b00 || (frag_rel == 2'b01 && sf == 0)) clip = fm;
                else clip = fm & ~sm & 255;
                n   = $countones(clip[7:0]);
                as_ = (fa * n + 4) / 8;
                if (frag_rel == 2'b00) begin
                    for (int ch = 0; ch < 3; ch++) mc[mb][p][ch] = nrm(col[ch], as_);
                    ma[mb][p] = as_; mm[mb][p] = fm; mf[mb][p] = 0;
                    if (sm != 0 && as_ != 255) rs[p] = 1;
                end else begin
                    for (int ch = 0; ch < 3; ch++)
                        mc[mb][p][ch] = sat(mc[mb][p][ch] + nrm(255 - sa, nrm(col[ch], as_)));
                    ma[mb][p] = sat(sa + nrm(255 - sa, as_));
                    rep = (frag_rel == 2'b01 && sf == 0 && sm != 0 &&
                           (fm & ~sm & 255) == 0 && fa > sa) ? 1 : 0;
                    if (rep == 1) begin mm[mb][p] = fm; mf[mb][p] = 1; end
                    else mm[mb][p] = sm | clip;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk(rd_data === exp_rd, cur_req, "rd_data", rd_data, exp_rd);
            chk(resub_valid === exp_rv, "R9", "resub_valid", 40'(resub_valid), 40'(exp_rv));
            chk(resub_need === exp_rn, "R9", "resub_need", 40'(resub_need), 40'(exp_rn));
        end
    end

    task automatic frag(int ad, int rel, logic [23:0] c, int a, int m);
        frag_valid = 1'b1; frag_addr = 9'(ad); frag_rel = 2'(rel);
        frag_color = c; frag_alpha = 8'(a); frag_mask = 8'(m);
        @(negedge clk);
        frag_valid = 1'b0;
    endtask

    task automatic end_tile(output logic need);
        sync_valid = 1'b1;
        @(negedge clk);
        sync_valid = 1'b0;
        need = resub_need;
    endtask

    task automatic peek(int ad, output logic [39:0] w);
        rd_addr = 9'(ad);
        @(negedge clk);
        w = rd_data;
    endtask

    task automatic xchk(string req, string what, int act, int exp);
        chk(act == exp, req, what, 40'(act), 40'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic [39:0] w;
        logic        nd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        armed = 1;

        // R1: empty banks after reset
        cur_req = "R1";
        peek(0, w);   xchk("R1", "rd_data px0", int'(w[31:0]), 0);
        peek(511, w); xchk("R1", "rd_data px511", int'(w[31:0]), 0);
        xchk("R1", "resub_valid", int'(resub_valid), 0);

        // tile 1
        cur_req = "R5";
        frag(5, 0, 24'hC86432, 128, 8'hFF);
        frag(5, 1, 24'h10F020, 255, 8'hE8);   // R5 replace, flag set
        frag(5, 1, 24'hFFFFFF, 255, 8'hE8);   // R6 clipped to nothing
        frag(6, 0, 24'h205080, 200, 8'h0F);
        frag(6, 1, 24'h808080, 100, 8'hF0);   // R5 OR
        frag(7, 0, 24'h112233, 255, 8'h33);
        frag(7, 2, 24'h445566, 255, 8'hFF);   // R7
        frag(8, 0, 24'h010203, 50, 8'h0F);
        frag(8, 2, 24'hFF0000, 255, 8'h0F);   // R7 no replace on equal
        frag(8, 1, 24'h00FF00, 255, 8'hF0);
        frag(9, 0, 24'h0A0B0C, 90, 8'h3C);
        frag(9, 3, 24'hFFFFFF, 255, 8'hFF);   // R8 skipped
        frag(10, 0, 24'h999999, 128, 8'hFF);
        frag(10, 0, 24'h123456, 255, 8'hFF);  // R3 overwrite, opaque
        end_tile(nd);
        xchk("R9", "need tile1", int'(nd), 0);

        peek(5, w);
        xchk("R5", "px5 mask", int'(w[7:0]), 'hE8);
        xchk("R6", "px5 alpha", int'(w[15:8]), 192);
        peek(6, w);  xchk("R5", "px6 mask", int'(w[7:0]), 'hFF);
        peek(7, w);  xchk("R7", "px7 mask", int'(w[7:0]), 'hFF);
        peek(8, w);
        xchk("R7", "px8 mask", int'(w[7:0]), 'hFF);
        xchk("R7", "px8 alpha", int'(w[15:8]), 25 + (2 * 230 * 128 + 255) / 510);
        peek(9, w);
        xchk("R8", "px9 mask", int'(w[7:0]), 'h3C);
        xchk("R2", "px9 alpha", int'(w[15:8]), 45);
        peek(10, w);
        xchk("R3", "px10 color", int'(w[39:16]), 'h123456);
        xchk("R3", "px10 alpha", int'(w[15:8]), 255);

        // tile 2: composing bank is separate from displayed one
        cur_req = "R10";
        frag(5, 0, 24'h000000, 255, 8'h0F);
        frag(11, 0, 24'h303030, 100, 8'hFF);
        frag(11, 0, 24'h404040, 100, 8'hFF);  // R9 visible data overwritten
        peek(5, w);  xchk("R10", "px5 held", int'(w[7:0]), 'hE8);
        peek(11, w); xchk("R10", "px11 hidden", int'(w[31:0]), 0);
        end_tile(nd);
        xchk("R9", "need tile2", int'(nd), 1);
        peek(5, w);  xchk("R10", "px5 new", int'(w[7:0]), 'h0F);
        peek(6, w);  xchk("R10", "px6 cleared", int'(w[31:0]), 0);
        end_tile(nd);
        xchk("R9", "need after clear", int'(nd), 0);
        peek(5, w);  xchk("R10", "px5 empty bank", int'(w[31:0]), 0);

        // random histories checked cycle by cycle against the model
        cur_req = "R4";
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 200; k++) begin
                frag($urandom % 16, $urandom % 4, 24'($urandom),
                     $urandom % 256, (k % 5 == 0) ? 8'hFF : 8'($urandom));
                if (k % 7 == 0) @(negedge clk);
            end
            end_tile(nd);
            for (int q = 0; q < 16; q++) peek(q, w);
        end

        armed = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule